// File: doc/BRIEF.md
# Single-Error-Correcting Word Store with Byte Merge

This block is a small on-chip memory that keeps its contents as 32-bit words. Each word has 6 check bits beside it. Every read recomputes the syndrome of the addressed word. If a single bit has flipped, in the data or in the check bits, the read returns the repaired data and raises a one-cycle flag. The stored copy is not rewritten by a read.

Requests carry a byte address. A whole-word write finishes in one cycle: it stores the new word and freshly computed check bits. A byte write is a two-cycle read-modify-write. In the first cycle the containing word is read and corrected. In the second cycle the new byte is placed into its lane and the whole word is written back with new check bits. A busy flag covers that second cycle. A test port can XOR masks into the stored data and check bits of any word without recomputing the check bits, so that the repair path can be exercised.

The code is a Hamming single-error-correcting code over codeword positions 1 to 38. The check bits sit at the power-of-two positions, and the 32 data bits fill the remaining positions in ascending order. Check bit c is the XOR of the data bits whose position has bit c set.

Top module: `ecc_word_store`

## Requirements
- R1: After reset, busy, rdValid and corrected are low. Every word reads back as zero with corrected low.
- R2: A read is accepted when reqValid=1, reqWrite=0 and busy=0. The word at index reqAddr[ADDR_W-1:2] appears on rdData with rdValid high in the following cycle only. The two low address bits do not affect a read.
- R3: A whole-word write (reqValid=1, reqWrite=1, reqWhole=1, busy=0) stores wrWord in the word at reqAddr[ADDR_W-1:2], together with fresh check bits, in a single cycle. busy stays low, and the low address bits have no effect.
- R4: A byte write (reqWhole=0) replaces byte lane reqAddr[1:0] of the addressed word with wrByte, where lane k is bits 8k+7 to 8k. The other three bytes are left unchanged. busy is high for exactly the one cycle after acceptance.
- R5: A request presented while busy is high is ignored. It changes no stored word and produces no rdValid.
- R6: When one stored data bit differs from the value written (injected with injDataMask), a read returns the originally written word with corrected high.
- R7: When one stored check bit is flipped (injCheckMask), a read returns the data unchanged with corrected high.
- R8: corrected is high only together with rdValid. It stays low for a word whose data and check bits are consistent.
- R9: A byte write to a word that holds a single-bit data error writes back the repaired other bytes and new check bits. A later read of that word returns the merged word with corrected low.
- R10: An injection (injEn=1) XORs injDataMask and injCheckMask into word injIdx without changing its check bits to match. Applying the same masks a second time restores a consistent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWhole | input | 1 | For writes: 1 = whole word, 0 = single byte |
| reqAddr | input | ADDR_W | Byte address |
| wrByte | input | 8 | Byte write data |
| wrWord | input | 32 | Whole-word write data |
| busy | output | 1 | Byte merge in progress; requests ignored |
| rdData | output | 32 | Corrected read word |
| rdValid | output | 1 | rdData valid this cycle |
| corrected | output | 1 | Nonzero syndrome on this read |
| injEn | input | 1 | Apply fault masks this cycle |
| injIdx | input | ADDR_W-2 | Word index to corrupt |
| injDataMask | input | 32 | XOR mask for stored data |
| injCheckMask | input | 6 | XOR mask for stored check bits |

## Verification
The assertions check the handshake timing on every cycle. An accepted read yields rdValid in the next cycle. A write never yields rdValid. A byte write raises busy for exactly one cycle, a whole write never raises it, and corrected never appears without rdValid. The data-path behaviour can only be shown by the bench's sweeps: that correction repairs each of the 32 data positions and each of the 6 check positions, that lane merging keeps the other bytes, that requests made while busy are dropped, and that a merge refreshes the check bits.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CW_LEN = DATA_W + CHK_W;

  typedef struct packed {
    logic rdCap;    // register corrected read word
    logic wrWhole;  // write full word from request
    logic holdCap;  // capture corrected word for merge
    logic wrMerge;  // write merged word back
  } ctrlStrobes_t;

  // codeword position of data bit i (skips powers of two)
  function automatic logic [CHK_W-1:0] dataPos(input int i);
    int p;
    int n;
    p = 0;
    n = 0;
    for (int q = 1; q <= CW_LEN; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == i) p = q;
        n++;
      end
    end
    return p[CHK_W-1:0];
  endfunction

  function automatic logic [CHK_W-1:0] calcCheck(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) c ^= dataPos(i);
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] fixData(input logic [DATA_W-1:0] d,
                                                input logic [CHK_W-1:0] syn);
    logic [DATA_W-1:0] r;
    r = d;
    for (int i = 0; i < DATA_W; i++)
      if (dataPos(i) == syn) r[i] = ~r[i];
    return r;
  endfunction
endpackage

// File: rtl/ecc_store_ctrl.sv
module ecc_store_ctrl
  import ecc_store_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         reqWhole,
  output ctrlStrobes_t strb,
  output logic         busy
);
  typedef enum logic {ST_IDLE, ST_MERGE} state_t;
  state_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (state == ST_MERGE) begin
      strb.wrMerge = 1'b1;
      stateNxt     = ST_IDLE;
    end else if (reqValid) begin
      if (!reqWrite)     strb.rdCap   = 1'b1;
      else if (reqWhole) strb.wrWhole = 1'b1;
      else begin
        strb.holdCap = 1'b1;
        stateNxt     = ST_MERGE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;

  assign busy = (state == ST_MERGE);
endmodule

// File: rtl/ecc_store_dp.sv
module ecc_store_dp
  import ecc_store_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          wrByte,
  input  logic [DATA_W-1:0]   wrWord,
  input  logic                injEn,
  input  logic [ADDR_W-3:0]   injIdx,
  input  logic [DATA_W-1:0]   injDataMask,
  input  logic [CHK_W-1:0]    injCheckMask,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic                corrected
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = 1 << IDX_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] memData [WORDS];
  logic [CHK_W-1:0]  memChk  [WORDS];

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rawData, fixedData;
  logic [CHK_W-1:0]  syn;

  logic [DATA_W-1:0] holdWord;
  logic [IDX_W-1:0]  holdIdx;
  logic [1:0]        holdLane;
  logic [7:0]        holdByte;
  logic [DATA_W-1:0] mergedWord;

  assign idx       = reqAddr[ADDR_W-1:2];
  assign rawData   = memData[idx];
  assign syn       = calcCheck(rawData) ^ memChk[idx];
  assign fixedData = fixData(rawData, syn);

  always_comb begin
    mergedWord = holdWord;
    for (int k = 0; k < LANES; k++)
      if (holdLane == 2'(k)) mergedWord[8*k +: 8] = holdByte;
  end

  // storage array with test-only corruption
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) begin
        memData[w] <= '0;
        memChk[w]  <= '0;
      end
    end else if (strb.wrWhole) begin
      memData[idx] <= wrWord;
      memChk[idx]  <= calcCheck(wrWord);
    end else if (strb.wrMerge) begin
      memData[holdIdx] <= mergedWord;
      memChk[holdIdx]  <= calcCheck(mergedWord);
    end else if (injEn) begin
      memData[injIdx] <= memData[injIdx] ^ injDataMask;
      memChk[injIdx]  <= memChk[injIdx] ^ injCheckMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdIdx  <= '0;
      holdLane <= '0;
      holdByte <= '0;
    end else if (strb.holdCap) begin
      holdWord <= fixedData;
      holdIdx  <= idx;
      holdLane <= reqAddr[1:0];
      holdByte <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      corrected <= 1'b0;
    end else begin
      rdValid   <= strb.rdCap;
      corrected <= strb.rdCap && (syn != '0);
      if (strb.rdCap) rdData <= fixedData;
    end
  end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_store_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWhole,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        wrByte,
  input  logic [31:0]       wrWord,
  output logic              busy,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              corrected,
  input  logic              injEn,
  input  logic [ADDR_W-3:0] injIdx,
  input  logic [31:0]       injDataMask,
  input  logic [5:0]        injCheckMask
);
  ctrlStrobes_t strb;

  ecc_store_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWhole(reqWhole), .strb(strb), .busy(busy)
  );

  ecc_store_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .wrByte(wrByte), .wrWord(wrWord), .injEn(injEn), .injIdx(injIdx),
    .injDataMask(injDataMask), .injCheckMask(injCheckMask),
    .rdData(rdData), .rdValid(rdValid), .corrected(corrected)
  );
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqWhole,
  input logic busy,
  input logic rdValid,
  input logic corrected
);
  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !busy) |=> rdValid); // R2
  AST_NO_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !busy) |=> !rdValid); // R3
  AST_WHOLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqWhole && !busy) |=> !busy); // R3
  AST_BYTE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqWhole && !busy) |=> busy); // R4
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R4
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid); // R5
  AST_CORR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    corrected |-> rdValid); // R8
endmodule

bind ecc_word_store ecc_word_store_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqWhole(reqWhole), .busy(busy), .rdValid(rdValid), .corrected(corrected)
);

// File: tb/sim_ecc_word_store.sv
`timescale 1ns/1ps
module sim_ecc_word_store;
  localparam int ADDR_W = 6;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqWhole = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0]  wrByte = '0;
  logic [31:0] wrWord = '0;
  logic busy, rdValid, corrected;
  logic [31:0] rdData;
  logic injEn = 0;
  logic [ADDR_W-3:0] injIdx = '0;
  logic [31:0] injDataMask = '0;
  logic [5:0]  injCheckMask = '0;

  int tests = 0, fails = 0;
  logic [31:0] mdl [WORDS];
  bit done = 0;

  always #5 clk = ~clk;

  ecc_word_store #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWhole(reqWhole), .reqAddr(reqAddr), .wrByte(wrByte), .wrWord(wrWord),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .corrected(corrected),
    .injEn(injEn), .injIdx(injIdx), .injDataMask(injDataMask),
    .injCheckMask(injCheckMask)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read word, compare data and corrected flag
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                        input bit expCorr, input string req);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check(rdValid && rdData == exp, req, rdData, exp);
    check(corrected == expCorr, req, 32'(corrected), 32'(expCorr));
  endtask

  task automatic doWhole(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqWhole = 1; reqAddr = a; wrWord = d;
    @(negedge clk);
    reqValid = 0; reqWhole = 0;
    check(!busy && !rdValid, "R3", 32'(busy), 0);
    mdl[a[ADDR_W-1:2]] = d;
  endtask

  task automatic doByte(input logic [ADDR_W-1:0] a, input logic [7:0] b);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqWhole = 0; reqAddr = a; wrByte = b;
    @(negedge clk);
    reqValid = 0;
    check(busy, "R4", 32'(busy), 1);
    @(negedge clk);
    check(!busy, "R4", 32'(busy), 0);
    mdl[a[ADDR_W-1:2]][8*a[1:0] +: 8] = b;
  endtask

  task automatic doInject(input int w, input logic [31:0] dm, input logic [5:0] cm);
    @(negedge clk);
    injEn = 1; injIdx = (ADDR_W-2)'(w); injDataMask = dm; injCheckMask = cm;
    @(negedge clk);
    injEn = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) mdl[w] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rdValid && !corrected, "R1", {busy, rdValid, corrected}, 0);
    rstN = 1;
    for (int w = 0; w < WORDS; w++) doRead(ADDR_W'(4*w), 32'h0, 0, "R1");

    // R3 whole writes with varied low address bits; R2 reads likewise
    for (int w = 0; w < WORDS; w++)
      doWhole(ADDR_W'(4*w + (w % 4)), 32'h9E3779B9 * (w + 1) ^ 32'(w << 24));
    for (int w = 0; w < WORDS; w++)
      doRead(ADDR_W'(4*w + ((w + 1) % 4)), mdl[w], 0, "R2");

    // R4 every lane of every word
    for (int w = 0; w < WORDS; w++)
      for (int k = 0; k < 4; k++) begin
        doByte(ADDR_W'(4*w + k), 8'(w * 16 + k * 5 + 1));
        doRead(ADDR_W'(4*w), mdl[w], 0, "R4");
      end

    // R5 request during busy is ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqWhole = 0; reqAddr = ADDR_W'(4*2 + 1); wrByte = 8'hA5;
    @(negedge clk);
    mdl[2][15:8] = 8'hA5;
    reqWhole = 1; reqAddr = ADDR_W'(4*7); wrWord = 32'hDEADBEEF;
    @(negedge clk);
    reqValid = 0; reqWhole = 0;
    check(!rdValid, "R5", 32'(rdValid), 0);
    doRead(ADDR_W'(4*7), mdl[7], 0, "R5");
    doRead(ADDR_W'(4*2), mdl[2], 0, "R5");

    // R6 / R10 each data bit, then undo
    for (int b = 0; b < 32; b++) begin
      doInject(3, 32'h1 << b, 6'h0);
      doRead(ADDR_W'(4*3), mdl[3], 1, "R6");
      doInject(3, 32'h1 << b, 6'h0);
      doRead(ADDR_W'(4*3), mdl[3], 0, "R10");
    end
    // R7 each check bit
    for (int c = 0; c < 6; c++) begin
      doInject(4, 32'h0, 6'h1 << c);
      doRead(ADDR_W'(4*4), mdl[4], 1, "R7");
      doInject(4, 32'h0, 6'h1 << c);
      doRead(ADDR_W'(4*4), mdl[4], 0, "R8");
    end

    // R9 merge repairs and refreshes check bits
    for (int b = 0; b < 32; b += 5) begin
      doInject(5, 32'h1 << b, 6'h0);
      doByte(ADDR_W'(4*5 + 2), 8'(b + 8'h30));
      doRead(ADDR_W'(4*5), mdl[5], 0, "R9");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule